// File: doc/BRIEF.md
# Crystal Clock Switchover Controller

After power-up the system clock comes from an internal oscillator. When a strap says a crystal is fitted, this block enables the crystal oscillator and counts its rising edges in the crystal's own clock domain. Once a set number of edges has been seen (1024 by default), the crystal is treated as stable. The block then hands the system clock over to the crystal through a glitch-free gate handshake, and finally drops the internal oscillator enable.

If the crystal has not proven itself within a timeout (ten seconds by default), the crystal enable is removed for good and the system stays on the internal oscillator. This lasts until the next reset. The timeout is counted in internal-clock cycles, derived from a parameter giving the internal oscillator frequency. A two-bit status output reports which outcome was reached.

Top module: `xtal_switchover`

## Requirements
- R1: While reset is asserted and right after it is released, `clk_sys` follows `clk_int`. In that window `int_osc_en` is 1, `sel_xtal` is 0 and `status` is 2'b00 (running on internal).
- R2: With `xtal_strap` low, `xtal_en` stays 0, `sel_xtal` stays 0 and `status` stays 2'b00, however long the block runs. No timeout failure is reported.
- R3: With `xtal_strap` high, `xtal_en` is 1 from reset release until a timeout failure.
- R4: `sel_xtal` does not rise before `STABLE_EDGES` rising edges of `clk_xtal` have occurred after reset release. A crystal that delivers only `STABLE_EDGES`-1 edges never causes a switch.
- R5: Once the edge count is reached before the timeout, `sel_xtal` becomes 1, `status` becomes 2'b01 (running on crystal) and `clk_sys` follows `clk_xtal`. This also holds when the crystal starts late but still inside the timeout.
- R6: `int_osc_en` falls only once the switch is complete, that is, while `status` is 2'b01 and `sel_xtal` is 1.
- R7: With the strap high and no completed count, a failure is entered `INT_CLK_HZ*TIMEOUT_S` internal cycles after reset release. On failure `xtal_en` becomes 0, `status` becomes 2'b10 (crystal failed) and the system clock stays on internal. The failure is sticky until reset.
- R8: The internal-clock gate and the crystal gate (`sel_xtal`) are never on together.
- R9: `status` never takes the value 2'b11. The states 2'b01 and 2'b10, once reached, persist until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal oscillator clock; the controller runs on it |
| clk_xtal | input | 1 | Raw crystal oscillator output |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_strap | input | 1 | High when a crystal is fitted; static while out of reset |
| clk_sys | output | 1 | Selected system clock |
| sel_xtal | output | 1 | Crystal gate enable of the glitch-free selector |
| int_osc_en | output | 1 | Internal oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| status | output | 2 | 00 on internal, 01 on crystal, 10 crystal failed |

## Verification
The assertions take for granted that `xtal_strap` is held steady for the whole time out of reset. They also assume the crystal toggles only while `xtal_en` is high, as a powered-down oscillator would. The stimulus respects both conditions. It sets the strap only while reset is held, and its crystal model is gated by `xtal_en`, so after a failure no edges reach the counter. Crystal half-periods are drawn at random between 3 and 9 ns against a 10 ns internal clock, and crystal start times are likewise randomised. Clock outputs are sampled at instants that never coincide with an edge of either source.

// File: rtl/xsw_pkg.sv
package xsw_pkg;

   typedef enum logic [1:0] {
      XSW_ON_INT  = 2'b00,
      XSW_ON_XTAL = 2'b01,
      XSW_FAILED  = 2'b10
   } xsw_status_e;

   typedef enum logic [2:0] {
      ST_WATCH,
      ST_HANDOVER,
      ST_ON_XTAL,
      ST_FAILED,
      ST_INT_ONLY
   } xsw_state_e;

endpackage

// File: rtl/xsw_sync.sv
module xsw_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xsw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/xsw_edge_count.sv
module xsw_edge_count #(
   parameter int STABLE_EDGES = 1024
) (
   input  logic clk_xtal,
   input  logic rst_n,
   output logic done
);

   localparam int EW = (STABLE_EDGES > 2) ? $clog2(STABLE_EDGES) : 1;
   localparam logic [EW-1:0] LAST = EW'(STABLE_EDGES - 1);

   logic [EW-1:0] cnt;

   always_ff @(posedge clk_xtal or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST) done <= 1'b1;
      end
   end

endmodule

// File: rtl/xsw_ctrl.sv
module xsw_ctrl
   import xsw_pkg::*;
#(
   parameter int TIMEOUT_CYC = 327680
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        strap,
   input  logic        done_s,
   input  logic        ack,
   output logic        req,
   output logic        int_osc_en,
   output logic        xtal_en,
   output logic [1:0]  status
);

   localparam int TW = $clog2(TIMEOUT_CYC);
   localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

   xsw_state_e    st;
   logic [TW-1:0] timer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_WATCH;
         timer <= '0;
      end else begin
         unique case (st)
            ST_WATCH: begin
               if (!strap)              st <= ST_INT_ONLY;
               else if (done_s)         st <= ST_HANDOVER;
               else if (timer == T_LAST) st <= ST_FAILED;
               else                     timer <= timer + 1'b1;
            end
            ST_HANDOVER: if (ack) st <= ST_ON_XTAL;
            default: st <= st;
         endcase
      end
   end

   always_comb begin
      req        = (st == ST_HANDOVER) || (st == ST_ON_XTAL);
      int_osc_en = (st != ST_ON_XTAL);
      xtal_en    = strap && ((st == ST_WATCH) || (st == ST_HANDOVER) || (st == ST_ON_XTAL));
      unique case (st)
         ST_ON_XTAL: status = XSW_ON_XTAL;
         ST_FAILED:  status = XSW_FAILED;
         default:    status = XSW_ON_INT;
      endcase
   end

endmodule

// File: rtl/xsw_clkmux.sv
module xsw_clkmux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_int,
   input  logic clk_xtal,
   input  logic rst_n,
   input  logic req,
   output logic clk_out,
   output logic gate_int,
   output logic gate_xtal,
   output logic ack
);

   logic xg_in_int;
   logic xreq_in_xtal;

   // crystal gate state seen in the internal domain
   xsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_xg (
      .clk(clk_int), .rst_n(rst_n), .d(gate_xtal), .q(xg_in_int)
   );

   // internal side: close on its own falling edge
   always_ff @(negedge clk_int or negedge rst_n) begin
      if (!rst_n) gate_int <= 1'b1;
      else        gate_int <= !req && !xg_in_int;
   end

   // crystal side: open only after internal gate is known closed
   xsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_req (
      .clk(clk_xtal), .rst_n(rst_n), .d(req && !gate_int), .q(xreq_in_xtal)
   );

   always_ff @(negedge clk_xtal or negedge rst_n) begin
      if (!rst_n) gate_xtal <= 1'b0;
      else        gate_xtal <= xreq_in_xtal;
   end

   assign ack     = xg_in_int;
   assign clk_out = (clk_int & gate_int) | (clk_xtal & gate_xtal);

endmodule

// File: rtl/xtal_switchover.sv
module xtal_switchover #(
   parameter int INT_CLK_HZ   = 32768,
   parameter int TIMEOUT_S    = 10,
   parameter int STABLE_EDGES = 1024,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk_int,
   input  logic       clk_xtal,
   input  logic       rst_n,
   input  logic       xtal_strap,
   output logic       clk_sys,
   output logic       sel_xtal,
   output logic       int_osc_en,
   output logic       xtal_en,
   output logic [1:0] status
);

   localparam int TIMEOUT_CYC = INT_CLK_HZ * TIMEOUT_S;

   if (STABLE_EDGES < 2) begin : g_bad_edges
      $error("xtal_switchover: STABLE_EDGES must be at least 2");
   end
   if (TIMEOUT_CYC < 4) begin : g_bad_timeout
      $error("xtal_switchover: timeout too short");
   end

   logic done_x;
   logic done_s;
   logic req;
   logic ack;
   logic gate_int;

   xsw_edge_count #(.STABLE_EDGES(STABLE_EDGES)) u_count (
      .clk_xtal(clk_xtal), .rst_n(rst_n), .done(done_x)
   );

   xsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
      .clk(clk_int), .rst_n(rst_n), .d(done_x), .q(done_s)
   );

   xsw_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
      .clk(clk_int), .rst_n(rst_n), .strap(xtal_strap), .done_s(done_s),
      .ack(ack), .req(req), .int_osc_en(int_osc_en), .xtal_en(xtal_en),
      .status(status)
   );

   xsw_clkmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
      .clk_int(clk_int), .clk_xtal(clk_xtal), .rst_n(rst_n), .req(req),
      .clk_out(clk_sys), .gate_int(gate_int), .gate_xtal(sel_xtal), .ack(ack)
   );

endmodule

// File: rtl/xtal_switchover_chk.sv
module xtal_switchover_chk (
   input logic       clk_int,
   input logic       rst_n,
   input logic       gate_int,
   input logic       sel_xtal,
   input logic       int_osc_en,
   input logic       xtal_en,
   input logic [1:0] status
);

   // R8
   gates_exclusive_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      !(gate_int && sel_xtal));

   // R6
   osc_off_late_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      !int_osc_en |-> (status == 2'b01) && sel_xtal);

   // R7
   xtal_drop_fail_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      $fell(xtal_en) |-> (status == 2'b10));

   // R7
   fail_sticky_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      (status == 2'b10) |=> (status == 2'b10) && !xtal_en && !sel_xtal);

   // R9
   xtal_sticky_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      (status == 2'b01) |=> (status == 2'b01));

   // R9
   status_legal_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      status != 2'b11);

endmodule

bind xtal_switchover xtal_switchover_chk u_chk (
   .clk_int(clk_int), .rst_n(rst_n), .gate_int(gate_int), .sel_xtal(sel_xtal),
   .int_osc_en(int_osc_en), .xtal_en(xtal_en), .status(status)
);

// File: tb/xtal_switchover_test.sv
`timescale 1ns/100ps
module xtal_switchover_test;

   localparam int CLK_PERIOD = 10;
   localparam int HZ     = 50;
   localparam int SECS   = 10;
   localparam int EDGES  = 64;

   logic clk_int = 1'b0;
   logic clk_xtal = 1'b0;
   logic rst_n = 1'b0;
   logic xtal_strap = 1'b0;
   logic clk_sys, sel_xtal, int_osc_en, xtal_en;
   logic [1:0] status;

   int n_chk = 0;
   int n_bad = 0;
   int xt_half = 5;
   int xt_limit = 0;
   int xt_edges = 0;
   bit xt_run = 1'b0;
   bit sel_seen = 1'b0;
   int edges_at_sel = -1;
   int cyc = 0;

   xtal_switchover #(.INT_CLK_HZ(HZ), .TIMEOUT_S(SECS), .STABLE_EDGES(EDGES)) uut (
      .clk_int(clk_int), .clk_xtal(clk_xtal), .rst_n(rst_n), .xtal_strap(xtal_strap),
      .clk_sys(clk_sys), .sel_xtal(sel_xtal), .int_osc_en(int_osc_en),
      .xtal_en(xtal_en), .status(status)
   );

   always #(CLK_PERIOD/2) clk_int = ~clk_int;

   // crystal model: toggles only while powered and allowed
   always begin
      if (xt_run && xtal_en && (xt_edges < xt_limit)) begin
         #(xt_half) clk_xtal = 1'b1;
         xt_edges = xt_edges + 1;
         #(xt_half) clk_xtal = 1'b0;
      end else begin
         clk_xtal = 1'b0;
         #1;
      end
   end

   always @(posedge sel_xtal) begin
      if (!sel_seen) begin
         sel_seen = 1'b1;
         edges_at_sel = xt_edges;
      end
   end

   function automatic int timeout_cycles();
      return HZ * SECS;
   endfunction

   function automatic int exp_status(input bit switched, input bit failed);
      if (failed)   return 2;
      if (switched) return 1;
      return 0;
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk_int) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
         summary();
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk_int);
      #2;
   endtask

   task automatic start(input bit strap);
      rst_n = 1'b0;
      xt_run = 1'b0;
      xt_limit = 1 << 30;
      xtal_strap = strap;
      repeat (3) @(posedge clk_int);
      #2;
      xt_edges = 0;
      sel_seen = 1'b0;
      edges_at_sel = -1;
      @(negedge clk_int);
      rst_n = 1'b1;
   endtask

   task automatic clk_follow(input string tag, input bit on_xtal);
      for (int k = 0; k < 6; k++) begin
         #1.3;
         check(tag, int'(clk_sys), on_xtal ? int'(clk_xtal) : int'(clk_int));
      end
   endtask

   task automatic wait_switch(input string tag);
      for (int k = 0; k < 400 && status != 2'b01; k++) cycles(1);
      check({tag, " R5 status"}, int'(status), exp_status(1, 0));
      check({tag, " R5 sel"}, int'(sel_xtal), 1);
      check({tag, " R4 edges before switch"}, int'(edges_at_sel >= EDGES), 1);
      check({tag, " R6 osc off"}, int'(int_osc_en), 0);
      check({tag, " R3 xtal_en"}, int'(xtal_en), 1);
      clk_follow({tag, " R5 clk_sys"}, 1'b1);
   endtask

   initial begin
      void'($urandom(32'd2718));

      // R1: reset state
      rst_n = 1'b0;
      xtal_strap = 1'b1;
      cycles(3);
      check("R1 reset status", int'(status), 0);
      check("R1 reset osc", int'(int_osc_en), 1);
      check("R1 reset sel", int'(sel_xtal), 0);
      clk_follow("R1 reset clk_sys", 1'b0);

      // R2: no crystal strapped
      start(1'b0);
      cycles(1);
      check("R1 released status", int'(status), 0);
      check("R2 xtal_en", int'(xtal_en), 0);
      clk_follow("R1 released clk_sys", 1'b0);
      xt_run = 1'b1;
      cycles(timeout_cycles() + 50);
      check("R2 status after timeout span", int'(status), exp_status(0, 0));
      check("R2 sel", int'(sel_xtal), 0);
      check("R2 osc", int'(int_osc_en), 1);
      check("R2 xtal_en late", int'(xtal_en), 0);

      // R5/R4: random crystal periods and start delays
      for (int it = 0; it < 5; it++) begin
         start(1'b1);
         xt_half = 3 + int'($urandom % 7);
         cycles(1 + int'($urandom % 100));
         check("R3 xtal_en waiting", int'(xtal_en), 1);
         xt_run = 1'b1;
         wait_switch("random");
      end

      // R5: late start, still inside the timeout
      start(1'b1);
      xt_half = 3;
      cycles(timeout_cycles() - 80);
      check("R3 late xtal_en", int'(xtal_en), 1);
      check("R5 late pre status", int'(status), 0);
      xt_run = 1'b1;
      wait_switch("late");

      // R4: one edge short, then timeout (R7)
      start(1'b1);
      xt_half = 4;
      xt_limit = EDGES - 1;
      xt_run = 1'b1;
      cycles(timeout_cycles() - 3);
      check("R4 short count no switch", int'(sel_seen), 0);
      check("R7 before timeout", int'(status), 0);
      check("R7 xtal_en before timeout", int'(xtal_en), 1);
      cycles(5);
      check("R7 after timeout status", int'(status), exp_status(0, 1));
      check("R7 xtal_en off", int'(xtal_en), 0);
      check("R7 osc stays", int'(int_osc_en), 1);
      clk_follow("R7 clk_sys internal", 1'b0);

      // R7: dead crystal, then a working crystal is ignored
      start(1'b1);
      cycles(timeout_cycles() + 2);
      check("R7 dead status", int'(status), exp_status(0, 1));
      xt_limit = 1 << 30;
      xt_half = 3;
      xt_run = 1'b1;
      cycles(300);
      check("R7 sticky status", int'(status), 2);
      check("R7 sticky sel", int'(sel_xtal), 0);
      check("R7 sticky edges", xt_edges, 0);

      summary();
   end

endmodule